// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is a 16-bit general-purpose timer that sits on a simple register bus. Software programs a divide ratio, a reference value and a few mode bits. The block then counts system-clock ticks through a prescaler. When the count meets the reference value, it raises a reference event flag and can drive a level interrupt. In restart mode the count returns to zero at the match. Otherwise it runs on and wraps.

The register file has the following entries:
- a mode word;
- a reference value;
- a capture word, which is plain storage only;
- the live counter, which can be read and loaded;
- an event word whose flags are cleared by writing ones to them.

Turning the timer off through the mode word also wipes the reference value. A write to the mode or reference register restarts both the prescaler and the count.

Top module: `refcmp_timer`

## Requirements
- R1: After reset, every readable register returns 0 and `irqOut` is low.
- R2: The mode, reference and capture registers are 16 bits wide at byte offsets 0x00, 0x04 and 0x08, and each reads back what was last written to it. The event register is at offset 0x11. Its bit 1 is the reference flag and its bit 0 is the capture flag, which always reads 0 here.
- R3: While mode bit 0 (run) is 0, the counter holds its value.
- R4: The mode register has these fields:
  - bit 0: run;
  - bits 2:1: clock source;
  - bit 3: restart on match;
  - bit 4: interrupt enable;
  - bits 15:8: prescale P.

  One counter tick occurs every P+1 clocks. A clock source of 2 makes it every 16*(P+1) clocks. Sources 0, 1 and 3 add no further division.
- R5: A write to the mode or the reference register sets the counter and the prescaler to zero.
- R6: A write to offset 0x0C loads the written value into the counter, and reading 0x0C returns the live count.
- R7: On a tick where the count equals the reference value, the reference flag is set. With mode bit 3 set, the counter becomes 0. With bit 3 clear, it increments and wraps from 0xFFFF to 0.
- R8: Writing the event register clears each flag whose data bit is 1. Bits written as 0 leave their flags unchanged.
- R9: `irqOut` is high exactly while mode bit 4 and the reference flag are both 1.
- R10: A mode write that changes bit 0 from 1 to 0 clears the reference register and stores the new mode value.
- R11: Reads of any other offset return 0, and writes to other offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data, combinational from `busAddr` |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit prescale field and a fixed divide-by-16 stage (DIV_LOG2 = 4). It uses small prescale values, so each ratio check, including 16*(P+1) = 32, settles in a few dozen clocks. Counter wrap is reached by loading 0xFFFE through the counter offset rather than by counting up to it.

// File: rtl/refcmp_pkg.sv
package refcmp_pkg;
  localparam int REG_W = 16;
  localparam int PRE_W = 8;

  localparam logic [4:0] OFF_MODE = 5'h00;
  localparam logic [4:0] OFF_REF  = 5'h04;
  localparam logic [4:0] OFF_CAP  = 5'h08;
  localparam logic [4:0] OFF_CNT  = 5'h0C;
  localparam logic [4:0] OFF_EVT  = 5'h11;

  localparam logic [1:0] SRC_DIV16 = 2'd2;

  // Field order matches the mode word, msb first.
  typedef struct packed {
    logic [PRE_W-1:0] preset;
    logic [1:0]       capEdge;
    logic             outMode;
    logic             refIrqEn;
    logic             restartOnRef;
    logic [1:0]       clkSrc;
    logic             run;
  } modeFields_t;

  typedef struct packed {
    logic             clear;
    logic             load;
    logic [REG_W-1:0] loadVal;
  } dpStrobe_t;
endpackage

// File: rtl/refcmp_dp.sv
module refcmp_dp
  import refcmp_pkg::*;
#(
  parameter int DIV_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  modeFields_t       mode,
  input  dpStrobe_t         strobe,
  input  logic [REG_W-1:0]  refVal,
  output logic [REG_W-1:0]  count,
  output logic              hit
);
  localparam int PC_W = PRE_W + DIV_LOG2;

  logic [PC_W-1:0] preCnt;
  logic [PC_W-1:0] preLimit;
  logic            tick;

  // (P+1)*2^DIV_LOG2 - 1 is just P with the low bits set.
  always_comb begin
    if (mode.clkSrc == SRC_DIV16)
      preLimit = {mode.preset, {DIV_LOG2{1'b1}}};
    else
      preLimit = {{DIV_LOG2{1'b0}}, mode.preset};
  end

  assign tick = mode.run && (preCnt == preLimit);
  assign hit  = tick && (count == refVal);

  always_ff @(posedge clk) begin
    if (!rstN)                       preCnt <= '0;
    else if (strobe.clear || !mode.run) preCnt <= '0;
    else if (tick)                   preCnt <= '0;
    else                             preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                           count <= '0;
    else if (strobe.clear)               count <= '0;
    else if (strobe.load)                count <= strobe.loadVal;
    else if (hit && mode.restartOnRef)   count <= '0;
    else if (tick)                       count <= count + 1'b1;
  end

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!mode.run && !strobe.clear && !strobe.load) |=> $stable(count));

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (count == '0));

  p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hit && mode.restartOnRef && !strobe.clear && !strobe.load) |=> (count == '0));

  p_load_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.clear) |=> (count == $past(strobe.loadVal)));
endmodule

// File: rtl/refcmp_ctrl.sv
module refcmp_ctrl
  import refcmp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWData,
  output logic [REG_W-1:0]  busRData,
  output logic              irqOut,
  input  logic [REG_W-1:0]  count,
  input  logic              hit,
  output modeFields_t       mode,
  output logic [REG_W-1:0]  refVal,
  output dpStrobe_t         strobe
);
  logic [REG_W-1:0] capReg;
  logic             evtRef;
  logic             wrEn;
  logic             selMode, selRef, selCap, selCnt, selEvt, selNone;

  assign wrEn    = busSel && busWr;
  assign selMode = (busAddr == ADDR_W'(OFF_MODE));
  assign selRef  = (busAddr == ADDR_W'(OFF_REF));
  assign selCap  = (busAddr == ADDR_W'(OFF_CAP));
  assign selCnt  = (busAddr == ADDR_W'(OFF_CNT));
  assign selEvt  = (busAddr == ADDR_W'(OFF_EVT));
  assign selNone = !(selMode || selRef || selCap || selCnt || selEvt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode   <= '0;
      refVal <= '0;
      capReg <= '0;
    end else if (wrEn) begin
      if (selMode) begin
        mode <= modeFields_t'(busWData);
        if (mode.run && !busWData[0]) refVal <= '0;
      end
      if (selRef) refVal <= busWData;
      if (selCap) capReg <= busWData;
    end
  end

  // A match in the same cycle as a clear keeps the flag set.
  always_ff @(posedge clk) begin
    if (!rstN)                              evtRef <= 1'b0;
    else if (hit)                           evtRef <= 1'b1;
    else if (wrEn && selEvt && busWData[1]) evtRef <= 1'b0;
  end

  always_comb begin
    strobe.clear   = wrEn && (selMode || selRef);
    strobe.load    = wrEn && selCnt;
    strobe.loadVal = busWData;
  end

  always_comb begin
    busRData = '0;
    if (selMode) busRData = REG_W'(mode);
    if (selRef)  busRData = refVal;
    if (selCap)  busRData = capReg;
    if (selCnt)  busRData = count;
    if (selEvt)  busRData = {{(REG_W-2){1'b0}}, evtRef, 1'b0};
  end

  assign irqOut = mode.refIrqEn && evtRef;

  p_hit_sets_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> evtRef);

  p_w1c_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && selEvt && busWData[1] && !hit) |=> !evtRef);

  p_off_clears_ref_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && selMode && mode.run && !busWData[0]) |=> (refVal == '0));

  p_unmapped_inert_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && selNone && !hit) |=> ($stable(mode) && $stable(refVal) && $stable(capReg) && $stable(evtRef)));
endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
  import refcmp_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DIV_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWData,
  output logic [15:0]       busRData,
  output logic              irqOut
);
  modeFields_t      mode;
  dpStrobe_t        strobe;
  logic [REG_W-1:0] refVal;
  logic [REG_W-1:0] count;
  logic             hit;

  refcmp_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .irqOut(irqOut), .count(count), .hit(hit), .mode(mode),
    .refVal(refVal), .strobe(strobe)
  );

  refcmp_dp #(.DIV_LOG2(DIV_LOG2)) i_dp (
    .clk(clk), .rstN(rstN), .mode(mode), .strobe(strobe),
    .refVal(refVal), .count(count), .hit(hit)
  );
endmodule

// File: tb/test_refcmp_timer.sv
module test_refcmp_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [15:0] busWData = '0;
  logic [15:0] busRData;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  refcmp_timer i_refcmp_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWData = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = busRData;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq", {15'd0, irqOut}, 16'd0);
    foreach (v[i]) ;
    rd(5'h00, v); chk("R1 mode", v, 0);
    rd(5'h04, v); chk("R1 ref", v, 0);
    rd(5'h08, v); chk("R1 cap", v, 0);
    rd(5'h0C, v); chk("R1 cnt", v, 0);
    rd(5'h11, v); chk("R1 evt", v, 0);
  endtask

  task automatic t_readback();
    logic [15:0] v;
    wr(5'h04, 16'h1234); wr(5'h08, 16'hBEEF); wr(5'h00, 16'h5A60);
    rd(5'h04, v); chk("R2 ref", v, 16'h1234);
    rd(5'h08, v); chk("R2 cap", v, 16'hBEEF);
    rd(5'h00, v); chk("R2 mode", v, 16'h5A60);
    rd(5'h11, v); chk("R2 evt", v, 0);
  endtask

  task automatic t_stopped();
    logic [15:0] v;
    wr(5'h0C, 16'h0042);
    rd(5'h0C, v); chk("R6 load", v, 16'h0042);
    waitN(10);
    rd(5'h0C, v); chk("R3 hold", v, 16'h0042);
  endtask

  task automatic t_restart();
    logic [15:0] v;
    wr(5'h00, 16'h0000);
    wr(5'h04, 16'h0005);
    wr(5'h00, 16'h001B);
    rd(5'h0C, v); chk("R5 zero after mode write", v, 0);
    waitN(5);
    rd(5'h0C, v); chk("R7 count at ref", v, 5);
    rd(5'h11, v); chk("R7 no flag yet", v, 0);
    chk("R9 irq low", {15'd0, irqOut}, 0);
    waitN(1);
    rd(5'h0C, v); chk("R7 restart to zero", v, 0);
    rd(5'h11, v); chk("R7 flag set", v, 16'h0002);
    chk("R9 irq high", {15'd0, irqOut}, 1);
    wr(5'h11, 16'h0000);
    rd(5'h11, v); chk("R8 zero write keeps flag", v, 16'h0002);
    wr(5'h11, 16'h0002);
    rd(5'h11, v); chk("R8 w1c clears", v, 0);
    chk("R9 irq follows flag", {15'd0, irqOut}, 0);
    waitN(3);
    wr(5'h04, 16'h0005);
    rd(5'h0C, v); chk("R5 zero after ref write", v, 0);
    wr(5'h00, 16'h000B);
    waitN(6);
    rd(5'h11, v); chk("R7 flag without irq enable", v, 16'h0002);
    chk("R9 irq masked", {15'd0, irqOut}, 0);
    wr(5'h11, 16'h0003);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    wr(5'h00, 16'h0000);
    wr(5'h04, 16'hFFFF);
    wr(5'h00, 16'h0203);
    waitN(2); rd(5'h0C, v); chk("R4 P=2 before tick", v, 0);
    waitN(1); rd(5'h0C, v); chk("R4 P=2 first tick", v, 1);
    waitN(3); rd(5'h0C, v); chk("R4 P=2 second tick", v, 2);
    wr(5'h00, 16'h0105);
    waitN(31); rd(5'h0C, v); chk("R4 div16 before tick", v, 0);
    waitN(1);  rd(5'h0C, v); chk("R4 div16 tick", v, 1);
    wr(5'h00, 16'h0001);
    waitN(1); rd(5'h0C, v); chk("R4 src0 no extra div", v, 1);
    wr(5'h00, 16'h0007);
    waitN(1); rd(5'h0C, v); chk("R4 src3 no extra div", v, 1);
  endtask

  task automatic t_free_wrap();
    logic [15:0] v;
    wr(5'h00, 16'h0000);
    wr(5'h04, 16'h0002);
    wr(5'h00, 16'h0003);
    waitN(3);
    rd(5'h0C, v); chk("R7 free-run continues past ref", v, 3);
    rd(5'h11, v); chk("R7 free-run flag", v, 16'h0002);
    wr(5'h11, 16'h0002);
    wr(5'h0C, 16'hFFFE);
    rd(5'h0C, v); chk("R6 load while running", v, 16'hFFFE);
    waitN(2);
    rd(5'h0C, v); chk("R7 wrap to zero", v, 0);
  endtask

  task automatic t_disable();
    logic [15:0] v;
    wr(5'h04, 16'h0077);
    wr(5'h00, 16'h0000);
    rd(5'h04, v); chk("R10 ref cleared", v, 0);
    rd(5'h00, v); chk("R10 mode stored", v, 0);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    wr(5'h04, 16'h00AA); wr(5'h08, 16'h0055); wr(5'h00, 16'h3300);
    wr(5'h14, 16'hFFFF); wr(5'h10, 16'hFFFF); wr(5'h02, 16'hFFFF); wr(5'h1F, 16'hFFFF);
    rd(5'h14, v); chk("R11 read 0x14", v, 0);
    rd(5'h10, v); chk("R11 read 0x10", v, 0);
    rd(5'h04, v); chk("R11 ref intact", v, 16'h00AA);
    rd(5'h08, v); chk("R11 cap intact", v, 16'h0055);
    rd(5'h00, v); chk("R11 mode intact", v, 16'h3300);
    rd(5'h0C, v); chk("R11 count intact", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_readback();
    t_stopped();
    t_restart();
    t_prescale();
    t_free_wrap();
    t_disable();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule